// File: doc/BRIEF.md
# Pen Interrupt Trigger Limiter

This block sits between a touch panel's level-sensitive pen-down interrupt and a scan engine that samples the panel's ADC channels. It turns the interrupt into single-cycle scan triggers and caps their rate. Each trigger masks the interrupt. After the scan engine reports completion, the block waits out whatever remains of the scan interval, then unmasks the interrupt again.

While the pen stays down, triggers therefore repeat at the interval rate. When the pen lifts, the interrupt goes quiet. A trailing timer, armed at unmask time, then fires exactly one more trigger so that the release is captured. Once that extra trigger has been served, the timer is no longer re-armed, and the block sits idle until the next pen-down.

All timing is counted in microseconds. A divider derives the microsecond tick from the system clock. A typical interval is 10000 us.

Top module: `pen_trig_limiter`

## Requirements
- R1: After reset `trig` is low, the block is masked, and no trigger occurs until `enable` is high.
- R2: With the block enabled and unmasked, a high `pen_irq` produces one trigger and masks the interrupt. While it stays masked, a held `pen_irq` produces no further trigger until `scan_done` has been seen.
- R3: After `scan_done`, the block unmasks once `interval_us - scan_time_us` microseconds have passed, if that difference is positive. Otherwise it unmasks in the next cycle.
- R4: At unmask, the trailing timer is started only if the extra-trigger count is zero. Its period is `interval_us` rounded up to whole milliseconds (1000 us units). On expiry it masks the interrupt, increments the count and issues one trigger. `interval_us` must be at least 1.
- R5: The trailing timer never restarts itself. After a timer-issued trigger and its `scan_done`, no trigger follows while `pen_irq` stays low.
- R6: A served `pen_irq` cancels a running trailing timer and clears the extra-trigger count, so the next unmask arms the timer again.
- R7: A low `enable` masks the interrupt and cancels the trailing timer. Raising `enable` unmasks the interrupt without starting the timer, even if a scan was still outstanding.
- R8: If `pen_irq` and a trailing-timer expiry coincide in one cycle, the interrupt path wins. Exactly one trigger is issued and the count is cleared.
- R9: `trig` is a pulse of exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low masks and cancels |
| pen_irq | input | 1 | Level pen-down interrupt, active high |
| scan_done | input | 1 | One-cycle pulse: the scan engine finished |
| interval_us | input | IVL_W | Desired scan interval in microseconds |
| scan_time_us | input | IVL_W | Measured duration of one scan in microseconds |
| trig | output | 1 | One-cycle scan trigger |

## Verification
The interrupt path and the trailing-timer expiry can both want to fire in the same cycle. The bench first measures, with the pen up, the exact cycle at which the timer's trigger appears after an aligned `scan_done`. It then repeats the identical sequence, with the same tick phase, while sweeping a one-cycle `pen_irq` pulse across the cycles around that point. Each run must show exactly one trigger, at the earlier of the interrupt's and the timer's cycles. Whether a further trailing trigger follows the next `scan_done` shows which path was taken: it must follow whenever the interrupt arrived no later than the expiry.

// File: rtl/pen_trig_pkg.sv
package pen_trig_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_BUSY,
        ST_HOLD
    } lim_state_e;

endpackage

// File: rtl/pen_us_tick.sv
module pen_us_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic tick_q;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;
            logic          tick_d;

            always_comb begin
                tick_d = (cnt_q == LAST);
                cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_d;
                    tick_q <= tick_d;
                end
            end

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q); // R3
        end else begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick_q <= 1'b0;
                else        tick_q <= 1'b1;
            end
        end
    endgenerate

    assign tick = tick_q;

endmodule

// File: rtl/pen_span_timer.sv
module pen_span_timer #(
    parameter int CNT_W = 16,
    parameter int UNIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             cancel,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             expire
);
    localparam int SUB_W = (UNIT > 1) ? $clog2(UNIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT - 1);

    logic             busy_d, busy_q;
    logic             exp_d, exp_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUB_W-1:0] sub_d, sub_q;

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        sub_d  = sub_q;
        exp_d  = 1'b0;
        if (cancel) begin
            busy_d = 1'b0;
        end else if (load) begin
            busy_d = 1'b1;
            cnt_d  = load_val;
            sub_d  = '0;
        end else if (busy_q && tick) begin
            if (sub_q == SUB_LAST) begin
                sub_d = '0;
                if (cnt_q <= CNT_W'(1)) begin
                    busy_d = 1'b0;
                    exp_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            exp_q  <= 1'b0;
            cnt_q  <= '0;
            sub_q  <= '0;
        end else begin
            busy_q <= busy_d;
            exp_q  <= exp_d;
            cnt_q  <= cnt_d;
            sub_q  <= sub_d;
        end
    end

    assign busy   = busy_q;
    assign expire = exp_q;

    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q |=> !exp_q); // R5

endmodule

// File: rtl/pen_trig_limiter.sv
module pen_trig_limiter
    import pen_trig_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int IVL_W      = 16,
    parameter int EXTRA_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pen_irq,
    input  logic             scan_done,
    input  logic [IVL_W-1:0] interval_us,
    input  logic [IVL_W-1:0] scan_time_us,
    output logic             trig
);
    localparam int US_PER_MS = 1000;
    localparam logic [EXTRA_W-1:0] EXTRA_MAX = {EXTRA_W{1'b1}};

    typedef struct packed {
        lim_state_e         state;
        logic [EXTRA_W-1:0] extra;
        logic               trig;
    } lim_regs_t;

    lim_regs_t r_d, r_q;

    logic             us_tick;
    logic             hold_load, hold_cancel, hold_busy, hold_exp;
    logic             trail_load, trail_cancel, trail_busy, trail_exp;
    logic [IVL_W-1:0] hold_gap;
    logic [IVL_W:0]   ivl_round;
    logic [IVL_W-1:0] trail_ms;

    pen_us_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    pen_span_timer #(.CNT_W(IVL_W), .UNIT(1)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (hold_load),
        .cancel   (hold_cancel),
        .load_val (hold_gap),
        .busy     (hold_busy),
        .expire   (hold_exp)
    );

    pen_span_timer #(.CNT_W(IVL_W), .UNIT(US_PER_MS)) u_trail (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (trail_load),
        .cancel   (trail_cancel),
        .load_val (trail_ms),
        .busy     (trail_busy),
        .expire   (trail_exp)
    );

    always_comb begin
        hold_gap  = (interval_us > scan_time_us) ? interval_us - scan_time_us : '0;
        ivl_round = {1'b0, interval_us} + (IVL_W+1)'(US_PER_MS - 1);
        trail_ms  = IVL_W'(ivl_round / (IVL_W+1)'(US_PER_MS));
    end

    always_comb begin
        r_d          = r_q;
        r_d.trig     = 1'b0;
        hold_load    = 1'b0;
        hold_cancel  = 1'b0;
        trail_load   = 1'b0;
        trail_cancel = 1'b0;
        if (!enable) begin
            r_d.state    = ST_OFF;
            hold_cancel  = 1'b1;
            trail_cancel = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_OFF: r_d.state = ST_IDLE;
                ST_IDLE: begin
                    if (pen_irq) begin
                        r_d.trig     = 1'b1;
                        r_d.extra    = '0;
                        r_d.state    = ST_BUSY;
                        trail_cancel = 1'b1;
                    end else if (trail_exp) begin
                        r_d.trig  = 1'b1;
                        r_d.state = ST_BUSY;
                        if (r_q.extra != EXTRA_MAX) r_d.extra = r_q.extra + 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (scan_done) begin
                        if (hold_gap != '0) begin
                            hold_load = 1'b1;
                            r_d.state = ST_HOLD;
                        end else begin
                            r_d.state  = ST_IDLE;
                            trail_load = (r_q.extra == '0);
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_exp) begin
                        r_d.state  = ST_IDLE;
                        trail_load = (r_q.extra == '0);
                    end
                end
                default: r_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_OFF, extra: '0, trig: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trig = r_q.trig;

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.trig |=> !r_q.trig); // R9
    AST_TRIG_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.trig |-> r_q.state == ST_BUSY); // R2
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !r_q.trig); // R7
    AST_HOLD_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy |-> r_q.state == ST_HOLD); // R3
    AST_ARM_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trail_busy) |-> r_q.extra == '0); // R4
    AST_IRQ_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pen_irq && r_q.state == ST_IDLE) |=> (!trail_busy && r_q.extra == '0)); // R6

endmodule

// File: tb/tb_pen_trig_limiter.sv
module tb_pen_trig_limiter;
    localparam int D  = 3;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          pen_irq = 1'b0;
    logic          scan_done = 1'b0;
    logic [IW-1:0] interval_us = 16'd40;
    logic [IW-1:0] scan_time_us = 16'd10;
    logic          trig;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;

    pen_trig_limiter #(.CLK_PER_US(D), .IVL_W(IW), .EXTRA_W(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .pen_irq      (pen_irq),
        .scan_done    (scan_done),
        .interval_us  (interval_us),
        .scan_time_us (scan_time_us),
        .trig         (trig)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic watch(input int n, output int cnt, output int first);
        cnt = 0;
        first = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trig) begin
                cnt++;
                if (first < 0) first = cyc;
            end
        end
    endtask

    task automatic wait_trig(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit && at < 0; i++) begin
            @(negedge clk);
            if (trig) at = cyc;
        end
    endtask

    task automatic pulse_done(output int c);
        @(negedge clk);
        scan_done = 1'b1;
        c = cyc;
        @(negedge clk);
        scan_done = 1'b0;
    endtask

    task automatic align();
        @(negedge clk);
        while (cyc % D != D - 1) @(negedge clk);
    endtask

    // Disable and re-enable, then serve one interrupt: BUSY with a cleared extra count.
    task automatic prime();
        int cnt, c2, f;
        pen_irq = 1'b0;
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        @(negedge clk); pen_irq = 1'b1;
        @(negedge clk);
        cnt = trig ? 1 : 0;
        pen_irq = 1'b0;
        watch(5, c2, f);
        check(cnt + c2 == 1, "R2", "prime trigger count", cnt + c2, 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int cnt, first, c, t, d, m, n, tt, lo, hi, s, tref, cnt2, f2, expn;
        int sts[5];
        int ivls[4];
        int stt[4];
        sts  = '{0, 10, 39, 40, 55};
        ivls = '{40, 1500, 1000, 2001};
        stt  = '{10, 1400, 1200, 2001};

        // R1: reset state
        repeat (4) @(negedge clk);
        check(trig == 1'b0, "R1", "trig during reset", int'(trig), 0);
        rst_n = 1'b1;
        pen_irq = 1'b1;
        watch(60, cnt, first);
        check(cnt == 0, "R1", "triggers while never enabled", cnt, 0);

        // R7: enabling unmasks; R2: held interrupt stays masked
        @(negedge clk); enable = 1'b1;
        watch(6, cnt, first);
        check(cnt == 1, "R7", "trigger after enable with pen down", cnt, 1);
        watch(400, cnt, first);
        check(cnt == 0, "R2", "retrigger without scan_done", cnt, 0);

        // R3: hold-off sweep with pen held down
        for (int k = 0; k < 5; k++) begin
            scan_time_us = IW'(sts[k]);
            m = (40 > sts[k]) ? 40 - sts[k] : 0;
            pulse_done(c);
            wait_trig(400, t);
            d = t - c;
            lo = (m > 0) ? m * D + 4 - D : 2;
            hi = (m > 0) ? m * D + 3 : 2;
            check(t >= 0 && d >= lo && d <= hi, "R3", "scan_done to retrigger cycles", d, m * D + 2);
            @(negedge clk);
            check(trig == 1'b0, "R9", "trigger width", int'(trig), 0);
        end
        pen_irq = 1'b0;

        // R4 / R5: trailing trigger after pen lift, with ms rounding
        for (int k = 0; k < 4; k++) begin
            interval_us = IW'(ivls[k]);
            scan_time_us = IW'(stt[k]);
            m = (ivls[k] > stt[k]) ? ivls[k] - stt[k] : 0;
            n = (ivls[k] + 999) / 1000;
            tt = m + n * 1000;
            prime();
            pulse_done(c);
            wait_trig(tt * D + 100, t);
            d = t - c;
            check(t >= 0 && d >= tt * D - 2 * D + 2 && d <= tt * D + 3, "R4",
                  "scan_done to trailing trigger cycles", d, tt * D);
            pulse_done(c);
            watch((3 * tt * D) / 2 + 50, cnt, first);
            check(cnt == 0, "R5", "triggers after trailing one", cnt, 0);
        end

        // R7: disable cancels a running trailing timer
        interval_us = 16'd40;
        scan_time_us = 16'd10;
        prime();
        pulse_done(c);
        watch(150, cnt, first);
        check(cnt == 0, "R4", "early trigger before trailing period", cnt, 0);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        watch(3200, cnt, first);
        check(cnt == 0, "R7", "trailing trigger after disable", cnt, 0);
        @(negedge clk); pen_irq = 1'b1;
        watch(4, cnt, first);
        check(cnt == 1, "R7", "interrupt unmasked after re-enable", cnt, 1);
        pen_irq = 1'b0;
        // R7: re-enable while a scan is outstanding also unmasks
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        @(negedge clk); pen_irq = 1'b1;
        watch(4, cnt, first);
        check(cnt == 1, "R7", "unmask after re-enable from busy", cnt, 1);
        pen_irq = 1'b0;

        // R8 / R6: reference expiry cycle, then sweep the interrupt around it
        prime();
        align();
        pulse_done(s);
        wait_trig(4000, t);
        tref = t - s;
        check(t >= 0, "R4", "reference trailing trigger seen", t, 1);
        pulse_done(c);
        watch(200, cnt, first);
        for (int off = tref - 5; off <= tref + 1; off++) begin
            prime();
            align();
            pulse_done(s);
            cnt = 0;
            first = -1;
            for (int i = 0; i < tref + 20; i++) begin
                @(negedge clk);
                if (trig) begin
                    cnt++;
                    if (first < 0) first = cyc - s;
                end
                pen_irq = (cyc - s == off);
            end
            pen_irq = 1'b0;
            expn = (off + 1 < tref) ? off + 1 : tref;
            check(cnt == 1, "R8", "triggers in contention window", cnt, 1);
            check(first == expn, "R8", "contention trigger cycle", first, expn);
            pulse_done(c);
            watch(2 * (30 + 1000) * D + 60, cnt2, f2);
            expn = (off + 1 <= tref) ? 1 : 0;
            check(cnt2 == expn, "R6", "re-armed trailing trigger", cnt2, expn);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule